// File: doc/BRIEF.md
# Multichannel Audio Slot Router

This block takes the subframes of one multichannel audio sample set, arriving one at a time on a 32-bit stream, and lays them out as a parallel bundle of eight output slots. Each subframe carries a channel index, a start-of-frame flag and a flat-sample flag. A routing table written through a small register port chooses the destination slot for every incoming channel. A channel enable mask sets which channels take part and when the bundle is complete.

Optional rules can zero the data of disabled channels and of flat samples. Optional transforms can reverse the bit order and then the byte order of every subframe as it is captured. A block-start identifier is compared with the low nibble of the first subframe of each frame. The result goes out with the bundle so a downstream packetiser can mark the start of an audio block.

Routing-table writes go to a shadow copy. The copy in use is reloaded only when a start-of-frame subframe is accepted, so a frame is never routed with a half-updated table. The bundle is emitted once per frame, after the subframe of the highest enabled channel.

Top module: `audio_slot_router`

## Requirements
- R1: After reset the output strobe, the block-start flag and all slot data are zero. The routing table is identity (channel i goes to slot i), and the block-start identifier is 0xF.
- R2: A write with `wrSel`=0 loads the configuration word. Its fields are: bits 7:0 enable mask, one bit per channel (bits 15:8 are ignored); bits 19:16 block-start identifier; bit 24 zero-disabled; bit 26 bit-reverse; bit 27 byte-swap; bit 29 zero-flat. A write with `wrSel`=1 loads the routing table: bits 3c+2:3c give the output slot for input channel c.
- R3: Suppose a subframe is accepted at a clock edge (`inValid` high) and its channel equals the highest set bit of the enable mask. Then `outValid` is low during the following cycle, high for exactly one cycle after the next edge, and low again afterwards.
- R4: Slot s (bits 32s+31:32s of `outSlots`) carries the last captured subframe of every channel c whose table field equals s. When several channels name the same slot, the highest such channel wins. A slot named by no channel carries zero.
- R5: A routing-table write takes effect only when the next start-of-frame subframe is accepted. A frame whose first subframe was accepted before the write is routed with the previous table.
- R6: With zero-disabled set, a channel whose mask bit is clear contributes all-zero data to its slot. With it clear, that channel's captured data is routed normally.
- R7: With zero-flat set, a subframe accepted with `inFlat` high is captured as zero. With zero-flat clear, `inFlat` has no effect.
- R8: With bit-reverse set, bit b of a captured subframe is bit 31-b of the input word.
- R9: With byte-swap set, byte k of the captured subframe is byte 3-k of the word after the bit-reverse stage.
- R10: `outBlockStart` is high together with `outValid` exactly when bits 3:0 of the most recent start-of-frame subframe equalled the block-start identifier. It is never high without `outValid`.
- R11: While the enable mask is all zero, `outValid` stays low whatever subframes arrive.
- R12: Between emissions `outSlots` holds its last value, even while the subframes of the next frame are being captured.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| wrEn | input | 1 | Register write strobe |
| wrSel | input | 1 | 0 selects the configuration word, 1 selects the routing table |
| wrData | input | 32 | Register write data |
| inValid | input | 1 | Subframe present this cycle |
| inSof | input | 1 | Subframe is the first of a frame |
| inChan | input | 3 | Channel index of the subframe |
| inFlat | input | 1 | Subframe is marked as a flat sample |
| inData | input | 32 | Subframe word |
| outValid | output | 1 | One-cycle strobe: slot bundle updated |
| outBlockStart | output | 1 | Frame opens an audio block, valid with outValid |
| outSlots | output | 256 | Eight 32-bit output slots, slot s at bits 32s+31:32s |

## Verification
The routing is swept over every channel count from one to eight. Each count is paired with odd-stride permutation tables, a fully reversed table and a many-to-one table, so that wrong field slicing, wrong winner order among colliding channels and missing zero-fill of untargeted slots each give different slot values. Bit-reverse, byte-swap, zero-flat and zero-disabled are toggled across the same sweep. Masks with holes show the emission point following the highest set bit rather than the channel count. Dedicated frames cover a table written mid-frame, a partially received frame that must leave the slots untouched, and block-start identifiers that match and then miss.

// File: rtl/aslot_pkg.sv
package aslot_pkg;
  parameter int NUM_CH = 8;
  parameter int SUB_W  = 32;
  parameter int ID_W   = 4;

  localparam int CH_W  = $clog2(NUM_CH);
  localparam int MAP_W = NUM_CH * CH_W;
  localparam int NBYTE = SUB_W / 8;

  // configuration word layout
  localparam int MASK_LSB    = 0;
  localparam int BLKID_LSB   = 16;
  localparam int ZINACT_BIT  = 24;
  localparam int BITREV_BIT  = 26;
  localparam int BYTEREV_BIT = 27;
  localparam int ZFLAT_BIT   = 29;

  typedef struct packed {
    logic [NUM_CH-1:0] mask;
    logic              zeroInactive;
    logic              bitRev;
    logic              byteRev;
    logic              zeroFlat;
    logic [ID_W-1:0]   blockId;
  } cfg_t;

  typedef struct packed {
    logic capture;     // store the current subframe
    logic sofCapture;  // current subframe opens a frame
    logic emit;        // publish the slot bundle
  } strobe_t;
endpackage

// File: rtl/aslot_ctrl.sv
module aslot_ctrl
  import aslot_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic              wrSel,
  input  logic [SUB_W-1:0]  wrData,
  input  logic              inValid,
  input  logic              inSof,
  input  logic [CH_W-1:0]   inChan,
  output cfg_t              cfg,
  output logic [MAP_W-1:0]  activeMap,
  output strobe_t           strb
);

  function automatic logic [MAP_W-1:0] identityMap();
    logic [MAP_W-1:0] m;
    for (int i = 0; i < NUM_CH; i++) m[i*CH_W +: CH_W] = CH_W'(i);
    return m;
  endfunction

  localparam cfg_t CFG_RST = '{mask: '0, zeroInactive: 1'b0, bitRev: 1'b0,
                               byteRev: 1'b0, zeroFlat: 1'b0, blockId: '1};

  logic [MAP_W-1:0] shadowMap;
  logic [CH_W-1:0]  topChan;
  logic             anyEn;
  logic             emitQ;
  logic             unusedWr;

  assign unusedWr = ^wrData;

  // highest enabled channel closes the frame
  always_comb begin
    topChan = '0;
    for (int i = 0; i < NUM_CH; i++)
      if (cfg.mask[i]) topChan = CH_W'(i);
    anyEn = |cfg.mask;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cfg <= CFG_RST;
    end else if (wrEn && !wrSel) begin
      cfg.mask         <= wrData[MASK_LSB +: NUM_CH];
      cfg.blockId      <= wrData[BLKID_LSB +: ID_W];
      cfg.zeroInactive <= wrData[ZINACT_BIT];
      cfg.bitRev       <= wrData[BITREV_BIT];
      cfg.byteRev      <= wrData[BYTEREV_BIT];
      cfg.zeroFlat     <= wrData[ZFLAT_BIT];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shadowMap <= identityMap();
      activeMap <= identityMap();
    end else begin
      if (wrEn && wrSel) shadowMap <= wrData[MAP_W-1:0];
      if (inValid && inSof) activeMap <= shadowMap;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) emitQ <= 1'b0;
    else       emitQ <= inValid && anyEn && (inChan == topChan);
  end

  always_comb begin
    strb.capture    = inValid;
    strb.sofCapture = inValid && inSof;
    strb.emit       = emitQ;
  end

endmodule

// File: rtl/aslot_datapath.sv
module aslot_datapath
  import aslot_pkg::*;
(
  input  logic                    clk,
  input  logic                    rstN,
  input  strobe_t                 strb,
  input  cfg_t                    cfg,
  input  logic [MAP_W-1:0]        activeMap,
  input  logic [CH_W-1:0]         inChan,
  input  logic                    inFlat,
  input  logic [SUB_W-1:0]        inData,
  output logic                    outValid,
  output logic                    outBlockStart,
  output logic [NUM_CH*SUB_W-1:0] outSlots
);

  logic [SUB_W-1:0] capQ [NUM_CH];
  logic [SUB_W-1:0] slotNext [NUM_CH];
  logic [SUB_W-1:0] revWord, bitStage, swapWord, capWord;
  logic             blkQ;

  for (genvar b = 0; b < SUB_W; b++) begin : g_rev
    assign revWord[b] = inData[SUB_W-1-b];
  end

  assign bitStage = cfg.bitRev ? revWord : inData;

  for (genvar k = 0; k < NBYTE; k++) begin : g_swap
    assign swapWord[k*8 +: 8] = bitStage[(NBYTE-1-k)*8 +: 8];
  end

  always_comb begin
    if (cfg.zeroFlat && inFlat) capWord = '0;
    else if (cfg.byteRev)       capWord = swapWord;
    else                        capWord = bitStage;
  end

  // later channels overwrite earlier ones on a shared slot
  always_comb begin
    for (int s = 0; s < NUM_CH; s++) begin
      slotNext[s] = '0;
      for (int c = 0; c < NUM_CH; c++)
        if (activeMap[c*CH_W +: CH_W] == CH_W'(s))
          slotNext[s] = (cfg.zeroInactive && !cfg.mask[c]) ? '0 : capQ[c];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int c = 0; c < NUM_CH; c++) capQ[c] <= '0;
      blkQ <= 1'b0;
    end else begin
      if (strb.capture)    capQ[inChan] <= capWord;
      if (strb.sofCapture) blkQ <= (inData[ID_W-1:0] == cfg.blockId);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      outValid      <= 1'b0;
      outBlockStart <= 1'b0;
      outSlots      <= '0;
    end else begin
      outValid      <= strb.emit;
      outBlockStart <= strb.emit && blkQ;
      if (strb.emit)
        for (int s = 0; s < NUM_CH; s++) outSlots[s*SUB_W +: SUB_W] <= slotNext[s];
    end
  end

endmodule

// File: rtl/audio_slot_router.sv
module audio_slot_router
  import aslot_pkg::*;
(
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    wrEn,
  input  logic                    wrSel,
  input  logic [SUB_W-1:0]        wrData,
  input  logic                    inValid,
  input  logic                    inSof,
  input  logic [CH_W-1:0]         inChan,
  input  logic                    inFlat,
  input  logic [SUB_W-1:0]        inData,
  output logic                    outValid,
  output logic                    outBlockStart,
  output logic [NUM_CH*SUB_W-1:0] outSlots
);

  cfg_t             cfgBus;
  logic [MAP_W-1:0] mapBus;
  strobe_t          strbBus;

  aslot_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrSel(wrSel), .wrData(wrData),
    .inValid(inValid), .inSof(inSof), .inChan(inChan),
    .cfg(cfgBus), .activeMap(mapBus), .strb(strbBus)
  );

  aslot_datapath u_dp (
    .clk(clk), .rstN(rstN), .strb(strbBus), .cfg(cfgBus), .activeMap(mapBus),
    .inChan(inChan), .inFlat(inFlat), .inData(inData),
    .outValid(outValid), .outBlockStart(outBlockStart), .outSlots(outSlots)
  );

endmodule

// File: rtl/audio_slot_router_chk.sv
module audio_slot_router_chk
  import aslot_pkg::*;
(
  input logic                    clk,
  input logic                    rstN,
  input logic                    inValid,
  input logic                    outValid,
  input logic                    outBlockStart,
  input logic [NUM_CH*SUB_W-1:0] outSlots,
  input logic [NUM_CH-1:0]       cfgMask
);

  // R3: a bundle only follows an accepted subframe two edges earlier
  a_r3_valid_follows_accept: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> $past(inValid, 2));

  // R10: block-start flag only travels with a bundle
  a_r10_block_with_valid: assert property (@(posedge clk) disable iff (!rstN)
    outBlockStart |-> outValid);

  // R11: no bundle when the mask was empty at the accepting edge
  a_r11_empty_mask_silent: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> ($past(cfgMask, 2) != '0));

  // R12: slot data changes only together with the strobe
  a_r12_slots_hold: assert property (@(posedge clk) disable iff (!rstN)
    !outValid |-> $stable(outSlots));

endmodule

bind audio_slot_router audio_slot_router_chk u_chk (
  .clk(clk), .rstN(rstN), .inValid(inValid), .outValid(outValid),
  .outBlockStart(outBlockStart), .outSlots(outSlots), .cfgMask(cfgBus.mask)
);

// File: tb/audio_slot_router_tb.sv
module audio_slot_router_tb;
  logic         clk = 1'b0;
  logic         rstN, wrEn, wrSel, inValid, inSof, inFlat;
  logic [31:0]  wrData, inData;
  logic [2:0]   inChan;
  logic         outValid, outBlockStart;
  logic [255:0] outSlots;

  always #10 clk = ~clk;

  audio_slot_router u_dut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrSel(wrSel), .wrData(wrData),
    .inValid(inValid), .inSof(inSof), .inChan(inChan), .inFlat(inFlat),
    .inData(inData), .outValid(outValid), .outBlockStart(outBlockStart),
    .outSlots(outSlots)
  );

  int errs = 0, checks = 0, frameNo = 0;
  bit done = 0;
  logic [7:0]  bMask;
  bit          bZI, bBR, bYR, bZF, bBlk;
  logic [3:0]  bId;
  logic [2:0]  bShadow [8];
  logic [2:0]  bActive [8];
  logic [31:0] bCap [8];
  logic [31:0] lastSlot [8];

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] xform(input logic [31:0] d, input bit flat);
    logic [31:0] r, s;
    for (int b = 0; b < 32; b++) r[b] = bBR ? d[31-b] : d[b];
    for (int k = 0; k < 4; k++) s[k*8 +: 8] = bYR ? r[(3-k)*8 +: 8] : r[k*8 +: 8];
    if (bZF && flat) s = '0;
    return s;
  endfunction

  function automatic logic [31:0] dataOf(input int c, input int f);
    return {8'(c*37 + f*11), 8'(f + 5), 8'(c*13 + 1), 4'(c + f), 4'(f + 3*c)};
  endfunction

  function automatic logic [23:0] mapOf(input int p);
    logic [23:0] m;
    for (int c = 0; c < 8; c++) begin
      case (p)
        0, 1, 2: m[c*3 +: 3] = 3'((c*(2*p+1) + p) & 7);
        3:       m[c*3 +: 3] = 3'(c >> 1);
        4:       m[c*3 +: 3] = 3'(7 - c);
        default: m[c*3 +: 3] = 3'(c);
      endcase
    end
    return m;
  endfunction

  function automatic int topOf();
    int t = -1;
    for (int c = 0; c < 8; c++) if (bMask[c]) t = c;
    return t;
  endfunction

  task automatic wrReg(input bit sel, input logic [31:0] d);
    @(negedge clk);
    wrEn = 1'b1; wrSel = sel; wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic setCfg(input logic [15:0] m, input bit zi, input bit br,
                        input bit yr, input bit zf, input logic [3:0] id);
    logic [31:0] w = '0;
    w[15:0] = m; w[19:16] = id; w[24] = zi; w[26] = br; w[27] = yr; w[29] = zf;
    wrReg(1'b0, w);
    bMask = m[7:0]; bZI = zi; bBR = br; bYR = yr; bZF = zf; bId = id;
  endtask

  task automatic setMap(input logic [23:0] m);
    wrReg(1'b1, {8'h00, m});
    for (int c = 0; c < 8; c++) bShadow[c] = m[c*3 +: 3];
  endtask

  task automatic pushSub(input int ch, input bit sof, input bit flat, input logic [31:0] d);
    @(negedge clk);
    inValid = 1'b1; inSof = sof; inChan = ch[2:0]; inFlat = flat; inData = d;
    @(negedge clk);
    inValid = 1'b0; inSof = 1'b0;
    if (sof) begin
      for (int c = 0; c < 8; c++) bActive[c] = bShadow[c];
      bBlk = (d[3:0] == bId);
    end
    bCap[ch] = xform(d, flat);
  endtask

  function automatic bit flatOf(input int c, input int f);
    return ((c + f) % 3) == 0;
  endfunction

  // sends channels startCh..top of the current frame, then checks the bundle
  task automatic runFrame(input string req, input int startCh);
    int top = topOf();
    int last = (top < 0) ? 7 : top;
    logic [31:0] e;
    for (int c = startCh; c <= last; c++)
      pushSub(c, c == 0, flatOf(c, frameNo), dataOf(c, frameNo));
    frameNo++;
    if (top < 0) begin
      for (int i = 0; i < 3; i++) begin
        chk({req, " R11 no strobe"}, 32'(outValid), 32'd0);
        @(negedge clk);
      end
      return;
    end
    chk({req, " R3 strobe not early"}, 32'(outValid), 32'd0);
    @(negedge clk);
    chk({req, " R3 strobe"}, 32'(outValid), 32'd1);
    chk({req, " R10 block flag"}, 32'(outBlockStart), 32'(bBlk));
    for (int s = 0; s < 8; s++) begin
      e = '0;
      for (int c = 0; c < 8; c++)
        if (bActive[c] == 3'(s)) e = (bZI && !bMask[c]) ? 32'd0 : bCap[c];
      lastSlot[s] = e;
      chk($sformatf("%s slot%0d", req, s), outSlots[s*32 +: 32], e);
    end
    @(negedge clk);
    chk({req, " R3 single cycle"}, 32'(outValid), 32'd0);
  endtask

  initial begin
    repeat (30000) @(posedge clk);
    if (!done) begin
      errs++; checks++;
      $display("FAIL R3 watchdog actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

  initial begin
    rstN = 1'b0; wrEn = 1'b0; wrSel = 1'b0; wrData = '0;
    inValid = 1'b0; inSof = 1'b0; inFlat = 1'b0; inChan = '0; inData = '0;
    bMask = '0; bZI = 0; bBR = 0; bYR = 0; bZF = 0; bId = 4'hF; bBlk = 0;
    for (int c = 0; c < 8; c++) begin
      bShadow[c] = 3'(c); bActive[c] = 3'(c); bCap[c] = '0; lastSlot[c] = '0;
    end
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1 strobe in reset", 32'(outValid), 32'd0);
    chk("R1 block flag in reset", 32'(outBlockStart), 32'd0);
    for (int s = 0; s < 8; s++) chk("R1 slot zero in reset", outSlots[s*32 +: 32], 32'd0);
    rstN = 1'b1;

    runFrame("R11 mask clear after reset", 0);
    setCfg(16'h00FF, 0, 0, 0, 0, 4'hF);
    runFrame("R1 identity table after reset", 0);
    setCfg(16'hFF03, 0, 0, 0, 0, 4'hF);
    runFrame("R2 upper mask bits ignored", 0);

    // sweep: channel count x table shape x transform options
    for (int n = 1; n <= 8; n++) begin
      for (int p = 0; p < 5; p++) begin
        setCfg(16'((1 << n) - 1), p[0], n[0], n[1], p[1], 4'hF);
        setMap(mapOf(p));
        runFrame("R4 R6 R7 R8 R9 sweep", 0);
      end
    end

    // holey masks: strobe after highest set bit, disabled channels zeroed or not
    for (int z = 0; z < 2; z++) begin
      setCfg(16'h0081, z[0], 0, 0, 0, 4'hF); setMap(mapOf(1)); runFrame("R6 mask 81", 0);
      setCfg(16'h005A, z[0], 1, 0, 1, 4'hF); setMap(mapOf(3)); runFrame("R6 mask 5A", 0);
      setCfg(16'h0024, z[0], 0, 1, 0, 4'hF); setMap(mapOf(4)); runFrame("R6 mask 24", 0);
    end

    // R5: table written mid-frame applies from the next frame
    setCfg(16'h00FF, 0, 0, 0, 0, 4'hF);
    setMap(mapOf(5));
    runFrame("R5 table loaded at frame start", 0);
    pushSub(0, 1'b1, flatOf(0, frameNo), dataOf(0, frameNo));
    setMap(mapOf(4));
    runFrame("R5 old table for frame in progress", 1);
    runFrame("R5 new table after next frame start", 0);

    // R12: partial frame leaves the bundle untouched
    for (int c = 0; c < 4; c++) begin
      pushSub(c, c == 0, flatOf(c, frameNo), dataOf(c, frameNo));
      chk("R12 no strobe mid-frame", 32'(outValid), 32'd0);
      for (int s = 0; s < 8; s++) chk("R12 slot held", outSlots[s*32 +: 32], lastSlot[s]);
    end
    runFrame("R12 frame completed", 4);

    // R10: identifier match and miss (channel 0 low nibble equals frameNo mod 16)
    setCfg(16'h0003, 0, 0, 0, 0, 4'(frameNo));
    runFrame("R10 identifier match", 0);
    chk("R10 match expected", 32'(bBlk), 32'd1);
    setCfg(16'h0003, 0, 0, 0, 0, 4'(frameNo + 1));
    runFrame("R10 identifier miss", 1'b0 ? 1 : 0);
    setCfg(16'h0003, 0, 0, 0, 0, 4'(frameNo + 3));
    runFrame("R10 identifier miss again", 0);
    chk("R10 miss expected", 32'(bBlk), 32'd0);

    // R11: mask written back to zero
    setCfg(16'h0000, 1, 0, 0, 0, 4'hF);
    runFrame("R11 mask written to zero", 0);
    for (int s = 0; s < 8; s++) chk("R11 R12 slots held", outSlots[s*32 +: 32], lastSlot[s]);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule